// File: doc/BRIEF.md
# NVM Command Dispatch Controller

This block sits between a debug and programming bus and a small non-volatile memory. It holds a 7-bit command register and decides which command runs and when it runs. Three kinds of trigger exist: an execute strobe, a bus read and a bus write. Each command answers to exactly one of them. The other two kinds of trigger leave that command alone. The block applies a read-and-write lock, runs a change-protection window for chip erase, and drives a busy flag. It also steers byte addresses into a page buffer.

The memory is a synchronous byte array made of `PAGES` pages of `PAGE_BYTES` bytes each. Page erase and page program operations change the array only when the operation completes. The same rule holds for a whole-array erase, an erase of the page buffer and chip erase. Each of these holds busy for `LATENCY` cycles. A CRC-32 run walks the array one byte per cycle and presents its result when busy drops.

Top module: `nvm_cmd_dispatch`

## Requirements
- R1: After reset, busy=0, err=0, cmd_q=0x00, bus_rdata=0xFF and crc_result=0. Every array byte and every page-buffer byte reads 0xFF.
- R2: A pulse on cmd_we stores all 7 bits of cmd_wdata into cmd_q at the next edge. Code 0x00 never starts an operation, whatever the trigger.
- R3: While cmd_q=0x43 and the block is idle, bus_re returns the array byte at bus_addr on bus_rdata in the next cycle. A bus_re under any other command returns 0xFF.
- R4: While cmd_q=0x23, bus_we writes bus_wdata into the page-buffer slot chosen by bus_addr[PB_W-1:0] without raising busy. The execute strobe with cmd_q=0x26 sets every buffer byte to 0xFF.
- R5: Under a bus_we, the page named by bus_addr[ADDR_W-1:PB_W] is changed as follows: 0x2B or 0x22 erases it to 0xFF, 0x2E or 0x24 programs it with the bitwise AND of the old data and the buffer, and 0x2F or 0x25 replaces it with the buffer. Under a bus_we, 0x20 erases the whole array. bus_wdata is ignored for these commands and the page buffer is kept.
- R6: Only the execute strobe starts 0x40, 0x26 and 0x78. An execute strobe under any other command is ignored, and a bus_we under one of these three commands is ignored.
- R7: An accepted erase, program or buffer-erase command raises busy for exactly LATENCY cycles, starting with the cycle after the trigger. CRC raises busy for PAGES*PAGE_BYTES cycles. When busy falls, cmd_q is 0x00 and the effect can be read back.
- R8: While busy, bus_re returns 0xFF. Any execute strobe, bus_we or bus_re that arrives while busy is dropped and sets err. err stays set until reset. A cmd_we that arrives while busy is ignored.
- R9: While lock_rw=1, only 0x40 and 0x78 are accepted. All other triggers leave busy, the array and the buffer unchanged, and reads return 0xFF.
- R10: Chip erase (0x40) starts only if its execute strobe comes k cycles after the cycle of an unlock_we pulse, where 1<=k<=UNLOCK_WIN. An accepted strobe closes the window. Chip erase sets the array and the buffer to 0xFF.
- R11: CRC (0x78) uses the reflected CRC-32 with polynomial 0xEDB88320, an initial value of all ones and an inverted final value. It runs over the array bytes from address 0 upward. The result appears on crc_result when busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 7 | New command code |
| exec_we | input | 1 | Execute strobe, used by action-triggered commands |
| unlock_we | input | 1 | Protection-unlock write, opens the chip-erase window |
| lock_rw | input | 1 | Read-and-write lock state |
| bus_we | input | 1 | Bus store into the memory-mapped space |
| bus_re | input | 1 | Bus load from the memory-mapped space |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Store data |
| bus_rdata | output | 8 | Load data, registered |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Sticky flag: a trigger was dropped while busy |
| cmd_q | output | 7 | Current command register |
| crc_result | output | 32 | Last CRC-32 result |

## Verification
The bench builds the block with PAGE_BYTES=4, PAGES=4, LATENCY=3 and UNLOCK_WIN=3. With these values, random page operations hit every one of the 16 array bytes many times. A full CRC pass takes only 16 cycles, so it can run more than once. A 3-cycle busy period leaves room for a dropped read, a dropped command write and a dropped store inside a single operation, and the dropped store lands in the completion cycle. A 3-cycle unlock window lets the bench test both edges of the window, k=UNLOCK_WIN and k=UNLOCK_WIN+1.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

    localparam logic [6:0] CMD_NOP          = 7'h00;
    localparam logic [6:0] CMD_APP_ERASE    = 7'h20;
    localparam logic [6:0] CMD_APP_PG_ERASE = 7'h22;
    localparam logic [6:0] CMD_LOAD_BUF     = 7'h23;
    localparam logic [6:0] CMD_APP_PG_PROG  = 7'h24;
    localparam logic [6:0] CMD_APP_PG_ERPR  = 7'h25;
    localparam logic [6:0] CMD_BUF_ERASE    = 7'h26;
    localparam logic [6:0] CMD_PG_ERASE     = 7'h2B;
    localparam logic [6:0] CMD_PG_PROG      = 7'h2E;
    localparam logic [6:0] CMD_PG_ERPR      = 7'h2F;
    localparam logic [6:0] CMD_CHIP_ERASE   = 7'h40;
    localparam logic [6:0] CMD_READ         = 7'h43;
    localparam logic [6:0] CMD_CRC          = 7'h78;

    typedef enum logic [2:0] {
        ARR_IDLE,
        ARR_ERASE_ALL,
        ARR_ERASE_PAGE,
        ARR_AND_PAGE,
        ARR_COPY_PAGE
    } arr_op_e;

    typedef struct packed {
        logic is_action;
        logic is_read;
        logic is_load;
        logic is_store_op;
        logic lock_ok;
        logic guarded;
    } cmd_class_t;

    function automatic logic [31:0] crc32_byte(logic [31:0] c, logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/nvm_cmd_class.sv
module nvm_cmd_class
    import nvm_cmd_pkg::*;
(
    input  logic [6:0] cmd,
    output cmd_class_t cls
);
    always_comb begin
        cls = '0;
        case (cmd)
            CMD_CHIP_ERASE: begin
                cls.is_action = 1'b1;
                cls.lock_ok   = 1'b1;
                cls.guarded   = 1'b1;
            end
            CMD_CRC: begin
                cls.is_action = 1'b1;
                cls.lock_ok   = 1'b1;
            end
            CMD_BUF_ERASE:  cls.is_action = 1'b1;
            CMD_READ:       cls.is_read   = 1'b1;
            CMD_LOAD_BUF:   cls.is_load   = 1'b1;
            CMD_APP_ERASE, CMD_APP_PG_ERASE, CMD_APP_PG_PROG, CMD_APP_PG_ERPR,
            CMD_PG_ERASE, CMD_PG_PROG, CMD_PG_ERPR:
                            cls.is_store_op = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/nvm_page_buffer.sv
module nvm_page_buffer #(
    parameter int PAGE_BYTES = 8,
    localparam int PB_W = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [PB_W-1:0]         idx,
    input  logic [7:0]              wdata,
    input  logic                    clear,
    output logic [PAGE_BYTES*8-1:0] flat
);
    logic [7:0] slot_q [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < PAGE_BYTES; i++) slot_q[i] <= 8'hFF;
        end else if (load) begin
            slot_q[idx] <= wdata;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign flat[g*8 +: 8] = slot_q[g];
    end
endmodule

// File: rtl/nvm_flash_array.sv
module nvm_flash_array
    import nvm_cmd_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int PAGES      = 8,
    localparam int PB_W   = $clog2(PAGE_BYTES),
    localparam int PG_W   = $clog2(PAGES),
    localparam int ADDR_W = PB_W + PG_W,
    localparam int DEPTH  = PAGE_BYTES * PAGES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  arr_op_e                 op,
    input  logic [PG_W-1:0]         page,
    input  logic [PAGE_BYTES*8-1:0] pbuf,
    input  logic [ADDR_W-1:0]       raddr_a,
    output logic [7:0]              rdata_a,
    input  logic [ADDR_W-1:0]       raddr_b,
    output logic [7:0]              rdata_b
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            case (op)
                ARR_ERASE_ALL:
                    for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
                ARR_ERASE_PAGE:
                    for (int j = 0; j < PAGE_BYTES; j++)
                        mem_q[{page, PB_W'(j)}] <= 8'hFF;
                ARR_AND_PAGE:
                    for (int j = 0; j < PAGE_BYTES; j++)
                        mem_q[{page, PB_W'(j)}] <= mem_q[{page, PB_W'(j)}] & pbuf[j*8 +: 8];
                ARR_COPY_PAGE:
                    for (int j = 0; j < PAGE_BYTES; j++)
                        mem_q[{page, PB_W'(j)}] <= pbuf[j*8 +: 8];
                default: ;
            endcase
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/nvm_cmd_dispatch.sv
module nvm_cmd_dispatch
    import nvm_cmd_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int PAGES      = 8,
    parameter int LATENCY    = 4,
    parameter int UNLOCK_WIN = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cmd_we,
    input  logic [6:0]                          cmd_wdata,
    input  logic                                exec_we,
    input  logic                                unlock_we,
    input  logic                                lock_rw,
    input  logic                                bus_we,
    input  logic                                bus_re,
    input  logic [$clog2(PAGE_BYTES*PAGES)-1:0] bus_addr,
    input  logic [7:0]                          bus_wdata,
    output logic [7:0]                          bus_rdata,
    output logic                                busy,
    output logic                                err,
    output logic [6:0]                          cmd_q,
    output logic [31:0]                         crc_result
);
    localparam int PB_W    = $clog2(PAGE_BYTES);
    localparam int PG_W    = $clog2(PAGES);
    localparam int ADDR_W  = PB_W + PG_W;
    localparam int DEPTH   = PAGE_BYTES * PAGES;
    localparam int LEN_MAX = (LATENCY > DEPTH) ? LATENCY : DEPTH;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);
    localparam int WIN_W   = $clog2(UNLOCK_WIN + 1);

    typedef struct packed {
        logic [6:0]       cmd;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [6:0]       op;
        logic [PG_W-1:0]  page;
        logic [WIN_W-1:0] win;
        logic             err;
        logic [7:0]       rdata;
        logic [31:0]      acc;
        logic [31:0]      crc;
    } state_t;

    state_t q, d;

    cmd_class_t             cls;
    arr_op_e                arr_op;
    logic                   buf_load;
    logic                   buf_clear;
    logic                   start;
    logic                   allowed;
    logic [CNT_W-1:0]       last;
    logic [7:0]             arr_rdata;
    logic [7:0]             crc_byte;
    logic [PAGE_BYTES*8-1:0] pbuf_flat;

    nvm_cmd_class u_class (
        .cmd (q.cmd),
        .cls (cls)
    );

    nvm_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_pbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (buf_load),
        .idx   (bus_addr[PB_W-1:0]),
        .wdata (bus_wdata),
        .clear (buf_clear),
        .flat  (pbuf_flat)
    );

    nvm_flash_array #(.PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (arr_op),
        .page    (q.page),
        .pbuf    (pbuf_flat),
        .raddr_a (bus_addr),
        .rdata_a (arr_rdata),
        .raddr_b (q.cnt[ADDR_W-1:0]),
        .rdata_b (crc_byte)
    );

    always_comb begin
        d         = q;
        arr_op    = ARR_IDLE;
        buf_load  = 1'b0;
        buf_clear = 1'b0;
        start     = 1'b0;
        allowed   = !lock_rw || cls.lock_ok;
        last      = (q.op == CMD_CRC) ? CNT_W'(DEPTH - 1) : CNT_W'(LATENCY - 1);

        if (q.win != '0) d.win = q.win - 1'b1;
        if (unlock_we)   d.win = WIN_W'(UNLOCK_WIN);

        if (q.busy) begin
            if (q.op == CMD_CRC) d.acc = crc32_byte(q.acc, crc_byte);
            if (q.cnt == last) begin
                d.busy = 1'b0;
                d.cnt  = '0;
                d.cmd  = CMD_NOP;
                case (q.op)
                    CMD_CHIP_ERASE: begin
                        arr_op    = ARR_ERASE_ALL;
                        buf_clear = 1'b1;
                    end
                    CMD_APP_ERASE:                   arr_op = ARR_ERASE_ALL;
                    CMD_BUF_ERASE:                   buf_clear = 1'b1;
                    CMD_PG_ERASE, CMD_APP_PG_ERASE:  arr_op = ARR_ERASE_PAGE;
                    CMD_PG_PROG,  CMD_APP_PG_PROG:   arr_op = ARR_AND_PAGE;
                    CMD_PG_ERPR,  CMD_APP_PG_ERPR:   arr_op = ARR_COPY_PAGE;
                    CMD_CRC:       d.crc = ~crc32_byte(q.acc, crc_byte);
                    default: ;
                endcase
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
            if (exec_we || bus_we || bus_re) d.err = 1'b1;
            if (bus_re) d.rdata = 8'hFF;
        end else begin
            if (exec_we && cls.is_action && allowed && (!cls.guarded || q.win != '0)) begin
                start = 1'b1;
                if (cls.guarded) d.win = '0;
            end
            if (bus_we && allowed) begin
                if (cls.is_load) begin
                    buf_load = 1'b1;
                end else if (cls.is_store_op) begin
                    start  = 1'b1;
                    d.page = bus_addr[ADDR_W-1:PB_W];
                end
            end
            if (bus_re) d.rdata = (cls.is_read && allowed) ? arr_rdata : 8'hFF;
            if (start) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.op   = q.cmd;
                d.acc  = '1;
            end else if (cmd_we) begin
                d.cmd = cmd_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.rdata <= 8'hFF;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata  = q.rdata;
    assign busy       = q.busy;
    assign err        = q.err;
    assign cmd_q      = q.cmd;
    assign crc_result = q.crc;
endmodule

// File: rtl/nvm_cmd_dispatch_chk.sv
module nvm_cmd_dispatch_chk
    import nvm_cmd_pkg::*;
#(
    parameter int LATENCY = 4,
    parameter int DEPTH   = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       exec_we,
    input logic       bus_we,
    input logic       bus_re,
    input logic       lock_rw,
    input logic       busy,
    input logic       err,
    input logic [6:0] cmd_q,
    input logic [7:0] bus_rdata
);
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R2
    nop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_q == CMD_NOP) |=> !busy);

    // R3
    non_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_re && cmd_q != CMD_READ) |=> bus_rdata == 8'hFF);

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == 16'(LATENCY) || run_q == 16'(DEPTH)));

    // R7
    nop_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cmd_q == CMD_NOP);

    // R8
    blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_re) |=> bus_rdata == 8'hFF);

    // R8
    drop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (exec_we || bus_we || bus_re)) |=> err);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R9
    lock_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_rw && !busy && bus_we && cmd_q != CMD_CHIP_ERASE && cmd_q != CMD_CRC) |=> !busy);
endmodule

bind nvm_cmd_dispatch nvm_cmd_dispatch_chk #(
    .LATENCY (LATENCY),
    .DEPTH   (PAGE_BYTES * PAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_we   (exec_we),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .lock_rw   (lock_rw),
    .busy      (busy),
    .err       (err),
    .cmd_q     (cmd_q),
    .bus_rdata (bus_rdata)
);

// File: tb/nvm_cmd_dispatch_test.sv
`timescale 1ns/100ps
module nvm_cmd_dispatch_test;
    localparam int PB    = 4;
    localparam int PG    = 4;
    localparam int LAT   = 3;
    localparam int WIN   = 3;
    localparam int DEPTH = PB * PG;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [6:0]    cmd_wdata = '0;
    logic          exec_we = 1'b0;
    logic          unlock_we = 1'b0;
    logic          lock_rw = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          busy;
    logic          err;
    logic [6:0]    cmd_q;
    logic [31:0]   crc_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_mem [DEPTH];
    logic [7:0] exp_buf [PB];

    nvm_cmd_dispatch #(.PAGE_BYTES(PB), .PAGES(PG), .LATENCY(LAT), .UNLOCK_WIN(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .exec_we(exec_we), .unlock_we(unlock_we), .lock_rw(lock_rw),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .busy(busy), .err(err), .cmd_q(cmd_q),
        .crc_result(crc_result)
    );

    always #2.5 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_crc();
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < DEPTH; i++) begin
            c = c ^ {24'h0, exp_mem[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cmd(logic [6:0] c);
        cmd_wdata = c; cmd_we = 1'b1;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic bwrite(logic [AW-1:0] a, logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic bread(logic [AW-1:0] a, output logic [7:0] v);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk); bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic pexec();
        exec_we = 1'b1; @(negedge clk); exec_we = 1'b0;
    endtask

    task automatic punlock();
        unlock_we = 1'b1; @(negedge clk); unlock_we = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic read_chk(string req, logic [AW-1:0] a);
        logic [7:0] v;
        wr_cmd(7'h43);
        bread(a, v);
        check(req, {24'h0, v}, {24'h0, exp_mem[a]});
    endtask

    task automatic page_op(string req, logic [6:0] c, logic [AW-1:0] a);
        int n;
        int pg = int'(a) / PB;
        wr_cmd(c);
        bwrite(a, 8'($urandom));
        busy_len(n);
        check({req, " busy length"}, 32'(n), 32'(LAT));
        check({req, " cmd back to nop"}, {25'h0, cmd_q}, 32'h0);
        for (int j = 0; j < PB; j++) begin
            case (c)
                7'h2B, 7'h22: exp_mem[pg*PB+j] = 8'hFF;
                7'h2E, 7'h24: exp_mem[pg*PB+j] = exp_mem[pg*PB+j] & exp_buf[j];
                default:      exp_mem[pg*PB+j] = exp_buf[j];
            endcase
        end
    endtask

    task automatic fill_page(int pg);
        wr_cmd(7'h23);
        for (int j = 0; j < PB; j++) begin
            exp_buf[j] = 8'($urandom) & 8'h7F;
            bwrite(AW'(pg*PB + j), exp_buf[j]);
        end
        page_op("R5 fill", 7'h2F, AW'(pg*PB));
    endtask

    initial begin
        idle(100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        for (int i = 0; i < PB; i++) exp_buf[i] = 8'hFF;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 busy", {31'h0, busy}, 32'h0);
        check("R1 err", {31'h0, err}, 32'h0);
        check("R1 cmd", {25'h0, cmd_q}, 32'h0);
        check("R1 rdata", {24'h0, bus_rdata}, 32'hFF);
        check("R1 crc", crc_result, 32'h0);
        for (int i = 0; i < DEPTH; i++) read_chk("R1 array erased", AW'(i));
        wr_cmd(7'h2F); bwrite('0, 8'h00);
        idle(LAT);
        read_chk("R1 buffer erased", '0);

        // R2 no-operation and full 7-bit register
        wr_cmd(7'h7F);
        check("R2 cmd 7 bits", {25'h0, cmd_q}, 32'h7F);
        wr_cmd(7'h00);
        pexec();
        check("R2 nop exec", {31'h0, busy}, 32'h0);
        bwrite(AW'(5), 8'h12);
        check("R2 nop store", {31'h0, busy}, 32'h0);
        bread(AW'(5), v);
        check("R3 non-read cmd gives FF", {24'h0, v}, 32'hFF);

        // R6 trigger class
        wr_cmd(7'h2E); pexec();
        check("R6 exec on store cmd", {31'h0, busy}, 32'h0);
        check("R6 cmd kept", {25'h0, cmd_q}, 32'h2E);
        wr_cmd(7'h26); bwrite(AW'(1), 8'h00);
        check("R6 store on action cmd", {31'h0, busy}, 32'h0);
        wr_cmd(7'h78); bwrite(AW'(1), 8'h00);
        check("R6 store on crc cmd", {31'h0, busy}, 32'h0);

        // R3 R4 R5 R7 random traffic
        for (int it = 0; it < 250; it++) begin
            int r = int'($urandom % 5);
            logic [AW-1:0] a = AW'($urandom);
            case (r)
                0: begin
                    wr_cmd(7'h23);
                    for (int k = 0; k < 1 + int'($urandom % PB); k++) begin
                        logic [AW-1:0] la = AW'($urandom);
                        logic [7:0] ld = 8'($urandom);
                        bwrite(la, ld);
                        exp_buf[int'(la) % PB] = ld;
                        check("R4 load no busy", {31'h0, busy}, 32'h0);
                    end
                end
                1: page_op("R5 erase", ($urandom % 2) ? 7'h2B : 7'h22, a);
                2: page_op("R5 program", ($urandom % 2) ? 7'h2E : 7'h24, a);
                3: page_op("R5 erase-program", ($urandom % 2) ? 7'h2F : 7'h25, a);
                default: read_chk("R3 random read", a);
            endcase
        end
        for (int i = 0; i < DEPTH; i++) read_chk("R5 array sweep", AW'(i));

        // R11 CRC over random contents
        wr_cmd(7'h78); pexec();
        busy_len(n);
        check("R7 crc busy length", 32'(n), 32'(DEPTH));
        check("R11 crc value", crc_result, model_crc());

        // R4 page buffer erase
        wr_cmd(7'h23); bwrite(AW'(2), 8'h3C); exp_buf[2] = 8'h3C;
        wr_cmd(7'h26); pexec();
        busy_len(n);
        check("R4 buffer erase busy", 32'(n), 32'(LAT));
        for (int j = 0; j < PB; j++) exp_buf[j] = 8'hFF;
        page_op("R4 buffer erased", 7'h25, AW'(PB));
        for (int j = 0; j < PB; j++) read_chk("R4 page from erased buffer", AW'(PB + j));

        // R5 whole-array erase
        wr_cmd(7'h20); bwrite(AW'(9), 8'h00);
        busy_len(n);
        check("R5 array erase busy", 32'(n), 32'(LAT));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        for (int i = 0; i < DEPTH; i++) read_chk("R5 array erased", AW'(i));
        wr_cmd(7'h78); pexec(); busy_len(n);
        check("R11 crc of erased array", crc_result, model_crc());

        // R10 change protection
        fill_page(0);
        wr_cmd(7'h40); pexec();
        check("R10 exec without unlock", {31'h0, busy}, 32'h0);
        punlock(); idle(WIN); pexec();
        check("R10 window expired", {31'h0, busy}, 32'h0);
        punlock(); idle(WIN - 1); pexec();
        check("R10 window edge accepted", {31'h0, busy}, 32'h1);
        busy_len(n);
        check("R10 chip erase busy", 32'(n), 32'(LAT));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        for (int j = 0; j < PB; j++) exp_buf[j] = 8'hFF;
        read_chk("R10 chip erase array", AW'(1));
        page_op("R10 chip erase buffer", 7'h2F, AW'(2*PB));
        read_chk("R10 buffer erased", AW'(2*PB + 1));

        // R9 lock
        fill_page(3);
        lock_rw = 1'b1;
        wr_cmd(7'h2B); bwrite(AW'(3*PB), 8'h00);
        check("R9 locked erase ignored", {31'h0, busy}, 32'h0);
        wr_cmd(7'h23); bwrite(AW'(0), 8'h00);
        wr_cmd(7'h43); bread(AW'(3*PB), v);
        check("R9 locked read FF", {24'h0, v}, 32'hFF);
        wr_cmd(7'h78); pexec(); busy_len(n);
        check("R9 crc under lock busy", 32'(n), 32'(DEPTH));
        check("R9 crc under lock value", crc_result, model_crc());
        lock_rw = 1'b0;
        read_chk("R9 page kept", AW'(3*PB));
        page_op("R9 buffer kept", 7'h25, AW'(PB));
        read_chk("R9 buffer byte kept", AW'(PB));
        lock_rw = 1'b1;
        wr_cmd(7'h40); punlock(); pexec();
        check("R9 chip erase under lock", {31'h0, busy}, 32'h1);
        busy_len(n);
        lock_rw = 1'b0;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        for (int j = 0; j < PB; j++) exp_buf[j] = 8'hFF;
        read_chk("R9 chip erase under lock result", AW'(3*PB));

        // R8 triggers while busy
        fill_page(2);
        fill_page(1);
        check("R8 err clear before", {31'h0, err}, 32'h0);
        wr_cmd(7'h2B); bwrite(AW'(PB), 8'h00);
        bread(AW'(2*PB), v);
        check("R8 blocked read FF", {24'h0, v}, 32'hFF);
        check("R8 err set", {31'h0, err}, 32'h1);
        wr_cmd(7'h43);
        bwrite(AW'(2*PB), 8'h00);
        busy_len(n);
        check("R8 cmd write ignored", {25'h0, cmd_q}, 32'h0);
        for (int j = 0; j < PB; j++) exp_mem[PB + j] = 8'hFF;
        read_chk("R8 started erase done", AW'(PB));
        read_chk("R8 dropped store", AW'(2*PB));
        check("R8 err sticky", {31'h0, err}, 32'h1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule